// File: doc/BRIEF.md
# ADC Result Placement Controller

This block is the digital back end of a multi-channel 10-bit analog-to-digital converter. It receives finished conversion codes from an abstract converter interface, one per cycle at most. It formats each code into a 16-bit word, either left- or right-justified, and stores the word in a file of eight result registers. A small configuration register sets the sequence length, the justification and the placement mode. This register is loaded by a one-cycle strobe.

Placement has two modes. In sequence mode the k-th result of a sequence goes to slot k, and the slot index returns to zero when the sequence completes. In FIFO mode a running pointer steps through the file across sequence boundaries and wraps after the last slot. In both modes, a start or an abort returns the pointer to slot zero. Each slot has a conversion-complete flag that software clears by writing a 1. The current pointer is exposed as a 4-bit status value. A one-cycle done pulse marks the end of each sequence. A compare-enable request from outside is passed through only while FIFO mode is off.

Top module: `adc_result_ctrl`

## Requirements
- R1: After reset, the slot pointer is 0, all flags are 0 and the done pulse is low. The configuration selects a sequence length of 4, left justification and sequence mode.
- R2: When the justification bit is 0, a code c is stored as {c, 6'b000000}. When the bit is 1, it is stored as {6'b000000, c}. `rd_data` shows the word in slot `rd_idx` combinationally.
- R3: The effective sequence length equals the 4-bit length field. A field value of 0, or any value above 8, gives a length of 8.
- R4: In sequence mode, the k-th accepted result after a start (k counted from 0) goes to slot k. The pointer returns to 0 when the result count reaches the length.
- R5: In FIFO mode, each accepted result goes to the current pointer. The pointer then advances by one and wraps from 7 to 0. Sequence completion does not reset it.
- R6: A `seq_start` or `seq_abort` pulse sets the pointer and the result count to 0 at the next edge. A conversion presented in the same cycle is discarded.
- R7: `seq_start` clears every flag at the same edge that resets the pointer. `seq_abort` leaves the flags unchanged.
- R8: Writing a result sets the flag of its slot. A 1 in bit i of `flag_clr` clears flag i. When a set and a clear hit the same flag in one cycle, the set wins.
- R9: `slot_ptr` is the slot that will receive the next result, zero-extended to 4 bits and always below 8.
- R10: `seq_done` is high for exactly the one cycle that follows the edge storing the result that makes the count since the last start or abort reach the length. This holds in both modes.
- R11: `cmp_active` equals `cmp_req` while FIFO mode is off and is 0 while FIFO mode is on.
- R12: A `cfg_load` strobe captures `cfg_len_in`, `cfg_right_in` and `cfg_fifo_in` at the edge. The new settings take effect from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Strobe that loads the configuration register |
| cfg_right_in | input | 1 | Justification bit to load (1 = right) |
| cfg_fifo_in | input | 1 | Placement mode to load (1 = FIFO) |
| cfg_len_in | input | 4 | Sequence length field to load |
| cmp_req | input | 1 | External request to enable automatic compare |
| seq_start | input | 1 | Start a new sequence |
| seq_abort | input | 1 | Abort the current conversion |
| conv_valid | input | 1 | A finished conversion code is present |
| conv_code | input | 10 | Unsigned conversion code |
| flag_clr | input | 8 | Write-1-to-clear mask for the flags |
| rd_idx | input | 3 | Slot selected for reading |
| rd_data | output | 16 | Stored word of the selected slot |
| done_flags | output | 8 | Per-slot conversion-complete flags |
| slot_ptr | output | 4 | Slot for the next result |
| seq_done | output | 1 | One-cycle end-of-sequence pulse |
| cmp_active | output | 1 | Compare enable after the FIFO-mode override |

## Verification
A new result setting a slot's flag can fall in the same cycle as a software clear of that same flag. A start or abort can fall in the same cycle as an arriving conversion. A directed case drives `flag_clr` at the slot that the pointer is about to fill while a conversion arrives. Another directed case pulses `seq_start` together with `conv_valid`. Random stimulus then repeats both collisions many times. The bench model resolves them by the stated priorities: the set wins, and the restart discards the conversion. It compares flags, pointer and stored words against the ports after every edge.

// File: rtl/adc_rp_pkg.sv
package adc_rp_pkg;

  // width of the programmable sequence length field
  localparam int unsigned SEQ_FIELD_W = 4;

  typedef struct packed {
    logic                   right_just;
    logic                   fifo_mode;
    logic [SEQ_FIELD_W-1:0] seq_len;
  } rp_cfg_t;

  localparam rp_cfg_t CFG_RESET = '{right_just: 1'b0, fifo_mode: 1'b0, seq_len: SEQ_FIELD_W'(4)};

  // effective sequence length: zero or anything past the file size means a full file
  function automatic int unsigned seq_len_of(logic [SEQ_FIELD_W-1:0] field, int unsigned nslot);
    int unsigned v;
    v = 32'(field);
    if (v == 0 || v > nslot) return nslot;
    return v;
  endfunction

  // next slot with wrap at the end of the file
  function automatic int unsigned slot_after(int unsigned slot, int unsigned nslot);
    return (slot + 1 >= nslot) ? 0 : slot + 1;
  endfunction

endpackage

// File: rtl/adc_rp_cfg.sv
module adc_rp_cfg
  import adc_rp_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load,
  input  rp_cfg_t cfg_in,
  output rp_cfg_t cfg_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg_q <= CFG_RESET;
    else if (load) cfg_q <= cfg_in;
  end

endmodule

// File: rtl/adc_rp_seq.sv
module adc_rp_seq
  import adc_rp_pkg::*;
#(
  parameter int unsigned NSLOT = 8,
  localparam int unsigned PTR_W = $clog2(NSLOT),
  localparam int unsigned CNT_W = $clog2(NSLOT + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   restart,
  input  logic                   conv_valid,
  input  logic                   fifo_mode,
  input  logic [SEQ_FIELD_W-1:0] len_field,
  output logic                   wr_en,
  output logic [PTR_W-1:0]       wr_slot,
  output logic                   seq_done
);

  logic [PTR_W-1:0] ptr_q, ptr_d, ptr_step;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, len_cnt;
  logic             last_hit;

  // a restart in the same cycle wins over an arriving code
  assign wr_en   = conv_valid & ~restart;
  assign wr_slot = ptr_q;

  always_comb begin
    len_cnt  = CNT_W'(seq_len_of(len_field, NSLOT));
    cnt_inc  = cnt_q + CNT_W'(1);
    last_hit = wr_en && (cnt_inc >= len_cnt);
    ptr_step = PTR_W'(slot_after(32'(ptr_q), NSLOT));
    ptr_d    = ptr_q;
    cnt_d    = cnt_q;
    if (restart) begin
      ptr_d = '0;
      cnt_d = '0;
    end else if (wr_en) begin
      cnt_d = last_hit ? '0 : cnt_inc;
      ptr_d = (last_hit && !fifo_mode) ? '0 : ptr_step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      cnt_q    <= '0;
      seq_done <= 1'b0;
    end else begin
      ptr_q    <= ptr_d;
      cnt_q    <= cnt_d;
      seq_done <= last_hit;
    end
  end

endmodule

// File: rtl/adc_rp_file.sv
module adc_rp_file #(
  parameter int unsigned NSLOT  = 8,
  parameter int unsigned CODE_W = 10,
  parameter int unsigned WORD_W = 16,
  localparam int unsigned PTR_W = $clog2(NSLOT),
  localparam int unsigned PAD_W = WORD_W - CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_slot,
  input  logic [CODE_W-1:0] code,
  input  logic              right_just,
  input  logic              clear_all,
  input  logic [NSLOT-1:0]  flag_clr,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_data,
  output logic [NSLOT-1:0]  flags
);

  function automatic logic [WORD_W-1:0] justify(logic [CODE_W-1:0] c, logic right);
    if (right) return {{PAD_W{1'b0}}, c};
    return {c, {PAD_W{1'b0}}};
  endfunction

  logic [WORD_W-1:0] word_q [NSLOT];
  logic [WORD_W-1:0] word_in;

  assign word_in = justify(code, right_just);
  assign rd_data = word_q[rd_idx];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_slot == PTR_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q[g] <= '0;
      else if (hit) word_q[g] <= word_in;
    end

    // set has priority over a software clear
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           flags[g] <= 1'b0;
      else if (clear_all)   flags[g] <= 1'b0;
      else if (hit)         flags[g] <= 1'b1;
      else if (flag_clr[g]) flags[g] <= 1'b0;
    end
  end

endmodule

// File: rtl/adc_result_ctrl.sv
module adc_result_ctrl
  import adc_rp_pkg::*;
#(
  parameter int unsigned NSLOT  = 8,
  parameter int unsigned CODE_W = 10,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned STAT_W = 4,
  localparam int unsigned PTR_W = $clog2(NSLOT)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_load,
  input  logic                   cfg_right_in,
  input  logic                   cfg_fifo_in,
  input  logic [SEQ_FIELD_W-1:0] cfg_len_in,
  input  logic                   cmp_req,
  input  logic                   seq_start,
  input  logic                   seq_abort,
  input  logic                   conv_valid,
  input  logic [CODE_W-1:0]      conv_code,
  input  logic [NSLOT-1:0]       flag_clr,
  input  logic [PTR_W-1:0]       rd_idx,
  output logic [WORD_W-1:0]      rd_data,
  output logic [NSLOT-1:0]       done_flags,
  output logic [STAT_W-1:0]      slot_ptr,
  output logic                   seq_done,
  output logic                   cmp_active
);

  rp_cfg_t          cfg_in, cfg_q;
  logic             fifo_mode;
  logic             restart;
  logic             wr_en;
  logic [PTR_W-1:0] wr_slot;

  assign cfg_in    = '{right_just: cfg_right_in, fifo_mode: cfg_fifo_in, seq_len: cfg_len_in};
  assign fifo_mode = cfg_q.fifo_mode;
  assign restart   = seq_start | seq_abort;

  adc_rp_cfg u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (cfg_load),
    .cfg_in (cfg_in),
    .cfg_q  (cfg_q)
  );

  adc_rp_seq #(.NSLOT(NSLOT)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .conv_valid (conv_valid),
    .fifo_mode  (fifo_mode),
    .len_field  (cfg_q.seq_len),
    .wr_en      (wr_en),
    .wr_slot    (wr_slot),
    .seq_done   (seq_done)
  );

  adc_rp_file #(.NSLOT(NSLOT), .CODE_W(CODE_W), .WORD_W(WORD_W)) u_file (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_slot    (wr_slot),
    .code       (conv_code),
    .right_just (cfg_q.right_just),
    .clear_all  (seq_start),
    .flag_clr   (flag_clr),
    .rd_idx     (rd_idx),
    .rd_data    (rd_data),
    .flags      (done_flags)
  );

  assign slot_ptr   = STAT_W'(wr_slot);
  // FIFO placement forces the automatic compare off
  assign cmp_active = cmp_req & ~fifo_mode;

endmodule

// File: rtl/adc_rp_chk.sv
module adc_rp_chk #(
  parameter int unsigned NSLOT  = 8,
  parameter int unsigned STAT_W = 4,
  localparam int unsigned PTR_W = $clog2(NSLOT)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              seq_start,
  input logic              seq_abort,
  input logic              wr_en,
  input logic [PTR_W-1:0]  wr_slot,
  input logic [STAT_W-1:0] slot_ptr,
  input logic [NSLOT-1:0]  done_flags,
  input logic              seq_done,
  input logic              fifo_mode,
  input logic              cmp_active
);

  logic [STAT_W-1:0] ptr_next_fifo;
  always_comb ptr_next_fifo = (slot_ptr == STAT_W'(NSLOT - 1)) ? '0 : slot_ptr + STAT_W'(1);

  // R6
  restart_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_start || seq_abort) |=> (slot_ptr == '0));

  // R7
  start_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> (done_flags == '0));

  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> done_flags[$past(wr_slot)]);

  // R10
  done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> $past(wr_en));

  // R11
  cmp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_mode |-> !cmp_active);

  // R9
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_ptr < STAT_W'(NSLOT));

  // R5
  fifo_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fifo_mode) |=> (slot_ptr == $past(ptr_next_fifo)));

endmodule

bind adc_result_ctrl adc_rp_chk #(.NSLOT(NSLOT), .STAT_W(STAT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .seq_start  (seq_start),
  .seq_abort  (seq_abort),
  .wr_en      (wr_en),
  .wr_slot    (wr_slot),
  .slot_ptr   (slot_ptr),
  .done_flags (done_flags),
  .seq_done   (seq_done),
  .fifo_mode  (fifo_mode),
  .cmp_active (cmp_active)
);

// File: tb/tb_adc_result_ctrl.sv
module tb_adc_result_ctrl;

  localparam time CLK_P = 20ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_load = 0, s_right = 0, s_fifo = 0, s_cmp = 0;
  logic [3:0]  s_len = 0;
  logic        s_start = 0, s_abort = 0, s_conv = 0;
  logic [9:0]  s_code = 0;
  logic [7:0]  s_clr = 0;
  logic [2:0]  s_rd = 0;
  logic [15:0] rd_data;
  logic [7:0]  done_flags;
  logic [3:0]  slot_ptr;
  logic        seq_done, cmp_active;

  int checks = 0;
  int errors = 0;

  always #(CLK_P / 2) clk = ~clk;

  adc_result_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(s_load), .cfg_right_in(s_right),
    .cfg_fifo_in(s_fifo), .cfg_len_in(s_len), .cmp_req(s_cmp),
    .seq_start(s_start), .seq_abort(s_abort), .conv_valid(s_conv),
    .conv_code(s_code), .flag_clr(s_clr), .rd_idx(s_rd), .rd_data(rd_data),
    .done_flags(done_flags), .slot_ptr(slot_ptr), .seq_done(seq_done),
    .cmp_active(cmp_active)
  );

  // reference model state
  logic [15:0] m_file [8];
  logic [7:0]  m_flags;
  int          m_ptr, m_cnt;
  logic        m_done, m_right, m_fifo;
  logic [3:0]  m_len_f;

  function automatic int eff_len(logic [3:0] f);
    if (f >= 4'd1 && f <= 4'd8) return int'(f);
    return 8;
  endfunction

  function automatic logic [15:0] fmt(logic [9:0] c, logic right);
    logic [15:0] w;
    w = {6'h00, c};
    return right ? w : (w << 6);
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    int len;
    logic [7:0] fl;
    len = eff_len(m_len_f);
    fl = m_flags & ~s_clr;
    m_done = 1'b0;
    if (s_start || s_abort) begin
      m_ptr = 0;
      m_cnt = 0;
      if (s_start) fl = '0;
    end else if (s_conv) begin
      m_file[m_ptr] = fmt(s_code, m_right);
      fl[m_ptr] = 1'b1;
      if (m_cnt + 1 >= len) begin
        m_cnt = 0;
        m_done = 1'b1;
        m_ptr = m_fifo ? (m_ptr + 1) % 8 : 0;
      end else begin
        m_cnt++;
        m_ptr = (m_ptr + 1) % 8;
      end
    end
    m_flags = fl;
    if (s_load) begin
      m_right = s_right;
      m_fifo  = s_fifo;
      m_len_f = s_len;
    end
  endtask

  task automatic compare();
    check("R2 rd_data", rd_data, m_file[s_rd]);
    check("R8 done_flags", {8'h00, done_flags}, {8'h00, m_flags});
    check("R9 slot_ptr", {12'h000, slot_ptr}, 16'(m_ptr));
    check("R10 seq_done", {15'h0, seq_done}, {15'h0, m_done});
    check("R11 cmp_active", {15'h0, cmp_active}, {15'h0, s_cmp & ~m_fifo});
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    s_start = 0; s_abort = 0; s_conv = 0; s_clr = 0; s_load = 0;
  endtask

  task automatic conv(logic [9:0] c);
    s_conv = 1; s_code = c;
    cyc();
  endtask

  task automatic peek(logic [2:0] idx, logic [15:0] exp, string tag);
    s_rd = idx;
    #1;
    check(tag, rd_data, exp);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_file[i] = '0;
    m_flags = 0; m_ptr = 0; m_cnt = 0; m_done = 0;
    m_right = 0; m_fifo = 0; m_len_f = 4'd4;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 slot_ptr", {12'h0, slot_ptr}, 16'h0);
    check("R1 done_flags", {8'h0, done_flags}, 16'h0);
    check("R1 seq_done", {15'h0, seq_done}, 16'h0);

    // R1 default length 4, left justified
    s_start = 1; cyc();
    conv(10'h3FF); conv(10'h001); conv(10'h155);
    check("R1 no done before 4th", {15'h0, seq_done}, 16'h0);
    conv(10'h2AA);
    check("R1 done after 4th", {15'h0, seq_done}, 16'h1);
    check("R4 pointer back to 0", {12'h0, slot_ptr}, 16'h0);
    check("R8 flags of four slots", {8'h0, done_flags}, 16'h000F);
    peek(3'd0, 16'hFFC0, "R2 left slot0");
    peek(3'd1, 16'h0040, "R2 left slot1");
    peek(3'd3, 16'hAA80, "R2 left slot3");

    // R12 / R3: length 11 clamps to 8, right justified, sequence mode
    s_load = 1; s_len = 4'd11; s_right = 1; s_fifo = 0; cyc();
    s_start = 1; cyc();
    for (int i = 0; i < 8; i++) begin
      conv(10'(i * 65 + 3));
      if (i == 3) check("R4 slot_ptr mid sequence", {12'h0, slot_ptr}, 16'h4);
      if (i < 7) check("R3 no early done", {15'h0, seq_done}, 16'h0);
    end
    check("R3 done after 8th", {15'h0, seq_done}, 16'h1);
    peek(3'd7, 16'd458, "R2 right slot7");

    // R5 FIFO mode, length 3
    s_load = 1; s_len = 4'd3; s_fifo = 1; cyc();
    s_start = 1; cyc();
    for (int i = 0; i < 5; i++) begin
      conv(10'(i + 100));
      if (i == 2) check("R10 fifo done at 3rd", {15'h0, seq_done}, 16'h1);
    end
    check("R5 pointer keeps running", {12'h0, slot_ptr}, 16'h5);
    for (int i = 0; i < 4; i++) conv(10'(i + 200));
    check("R5 pointer wrapped", {12'h0, slot_ptr}, 16'h1);

    // R6 / R7 abort keeps flags, start clears them
    s_abort = 1; cyc();
    check("R6 abort pointer", {12'h0, slot_ptr}, 16'h0);
    check("R7 abort keeps flags", {8'h0, done_flags}, 16'h00FF);
    s_start = 1; s_conv = 1; s_code = 10'h3A5; cyc();
    check("R6 start pointer", {12'h0, slot_ptr}, 16'h0);
    check("R7 start clears flags", {8'h0, done_flags}, 16'h0);
    conv(10'h011);
    check("R6 first result in slot0", {12'h0, slot_ptr}, 16'h1);

    // R8 collision of set and clear
    s_clr = 8'h03; conv(10'h022);
    check("R8 set beats clear", {8'h0, done_flags}, 16'h0002);

    // R11 / R12 compare override and load timing
    s_cmp = 1; #1;
    check("R11 fifo forces off", {15'h0, cmp_active}, 16'h0);
    s_load = 1; s_fifo = 0; #1;
    check("R12 not before edge", {15'h0, cmp_active}, 16'h0);
    cyc();
    check("R11 passes in sequence mode", {15'h0, cmp_active}, 16'h1);

    // random phase
    void'($urandom(32'h5EED_0A1C));
    for (int n = 0; n < 4000; n++) begin
      s_conv  = ($urandom % 100) < 60;
      s_code  = 10'($urandom);
      s_start = ($urandom % 100) < 2;
      s_abort = ($urandom % 100) < 2;
      s_clr   = (($urandom % 10) == 0) ? 8'($urandom) : 8'h00;
      s_load  = ($urandom % 100) < 3;
      s_len   = 4'($urandom);
      s_right = 1'($urandom);
      s_fifo  = 1'($urandom);
      s_cmp   = 1'($urandom);
      s_rd    = 3'($urandom);
      cyc();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule